// File: doc/BRIEF.md
# Morse Code Keyer

This block turns ASCII characters into on/off keying for a transmitter and a matching indicator lamp. A producer hands over one character at a time on a valid/ready input. The block looks the character up in a built-in codebook in which each symbol's pattern of dots and dashes is packed into a single byte. It then plays the elements out against a time unit whose length, in clock cycles, is set by a parameter.

While a character is being sent, `busy` is high and `char_ready` is low, so the producer simply waits. Digits, uppercase letters and the space character are understood. Any other byte produces only the silence that separates two characters, so the block cannot stall on unknown input.

Top module: `morse_keyer`

## Requirements
- R1: `char_ready` is high exactly when no character is in progress. A character is taken on a rising clock edge where `char_valid` and `char_ready` are both high. `busy` rises in the cycle after that edge and stays high until the last unit of that character's trailing silence has ended.
- R2: A codebook byte is read from its most significant bit. A 1 is a dash and a 0 is a dot. The last element is followed by a single 1 bit and then zeros. The byte shifts left by one after each element, and element output ends when the remaining byte is 0x80. A dot keys for 1 unit and a dash keys for 3 units.
- R3: Uppercase letters 'A' (0x41) to 'Z' (0x5A) send their standard international patterns (for example A = dot dash, B = dash dot dot dot, Q = dash dash dot dash).
- R4: Digits '0' (0x30) to '9' (0x39) send five-element patterns. For example, 0 = five dashes, 5 = five dots, 7 = dash dash dot dot dot, and 9 = four dashes and a dot.
- R5: Every element, dot or dash, is followed by exactly 1 unit with the key off.
- R6: After the gap that follows the final element of a character, a further 3 units of key-off silence are sent before the block is ready again.
- R7: The space character (0x20) produces 7 units of silence and no key-on time.
- R8: Any byte that is not a digit, an uppercase letter or a space (lowercase letters included) produces only 3 units of silence.
- R9: `lamp_n` is low whenever `key_out` is high, and high whenever `key_out` is low.
- R10: `char_valid` and `char_data` have no effect while a character is in progress.
- R11: With synchronous `rst` high, the block returns to idle on the next edge: `key_out` low, `lamp_n` high, `busy` low, `char_ready` high. A character in progress is abandoned.
- R12: One time unit lasts exactly `UNIT_CYCLES` clock cycles, counted from the edge on which the character was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | Character offered |
| char_data | input | 8 | ASCII character |
| char_ready | output | 1 | Block idle and able to take a character |
| key_out | output | 1 | Transmitter key, high while a mark is sent |
| lamp_n | output | 1 | Active-low indicator lamp |
| busy | output | 1 | A character is being sent |

## Verification
The bench builds the keyer with `UNIT_CYCLES` set to 3. At that value a unit is short enough that every letter and digit pattern, the 7-unit space and the 3-unit silence for unknown bytes all fit in a few dozen cycles. It is also long enough that an error of one cycle at the edge of a unit, or a unit that ignores its divider, shows up as a key level mismatch. Each character's waveform is compared cycle by cycle against a pattern written in the bench as an element count and a dash mask read from the least significant bit, which is independent of the packed codebook. Characters are sent back to back, so the return of `char_ready` in the first idle cycle is exercised on every vector.

// File: rtl/morse_pkg.sv
package morse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_GAP,
        ST_TAIL
    } seq_state_e;

    typedef enum logic {
        CLS_SYMBOL,
        CLS_WORD_GAP
    } char_class_e;

    typedef struct packed {
        char_class_e cls;
        logic [7:0]  code;
    } char_entry_t;

    localparam logic [7:0] CODE_DONE   = 8'h80;
    localparam logic [2:0] UNITS_DOT   = 3'd1;
    localparam logic [2:0] UNITS_DASH  = 3'd3;
    localparam logic [2:0] UNITS_GAP   = 3'd1;
    localparam logic [2:0] UNITS_CHAR  = 3'd3;
    localparam logic [2:0] UNITS_WORD  = 3'd7;

    function automatic logic [7:0] digit_code(input logic [3:0] d);
        logic [7:0] c;
        case (d)
            4'd0: c = 8'hFC;
            4'd1: c = 8'h7C;
            4'd2: c = 8'h3C;
            4'd3: c = 8'h1C;
            4'd4: c = 8'h0C;
            4'd5: c = 8'h04;
            4'd6: c = 8'h84;
            4'd7: c = 8'hC4;
            4'd8: c = 8'hE4;
            4'd9: c = 8'hF4;
            default: c = CODE_DONE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] letter_code(input logic [4:0] l);
        logic [7:0] c;
        case (l)
            5'd0:  c = 8'h60;
            5'd1:  c = 8'h88;
            5'd2:  c = 8'hA8;
            5'd3:  c = 8'h90;
            5'd4:  c = 8'h40;
            5'd5:  c = 8'h28;
            5'd6:  c = 8'hD0;
            5'd7:  c = 8'h08;
            5'd8:  c = 8'h20;
            5'd9:  c = 8'h78;
            5'd10: c = 8'hB0;
            5'd11: c = 8'h48;
            5'd12: c = 8'hE0;
            5'd13: c = 8'hA0;
            5'd14: c = 8'hF0;
            5'd15: c = 8'h68;
            5'd16: c = 8'hD8;
            5'd17: c = 8'h50;
            5'd18: c = 8'h10;
            5'd19: c = 8'hC0;
            5'd20: c = 8'h30;
            5'd21: c = 8'h18;
            5'd22: c = 8'h70;
            5'd23: c = 8'h98;
            5'd24: c = 8'hB8;
            5'd25: c = 8'hC8;
            default: c = CODE_DONE;
        endcase
        return c;
    endfunction

    function automatic logic [2:0] units_for_msb(input logic [7:0] code);
        return code[7] ? UNITS_DASH : UNITS_DOT;
    endfunction

endpackage

// File: rtl/morse_codebook.sv
module morse_codebook
    import morse_pkg::*;
(
    input  logic [7:0]  ascii,
    output char_entry_t entry
);
    logic [7:0] digit_off;
    logic [7:0] letter_off;
    logic       is_digit;
    logic       is_letter;
    logic       is_space;

    always_comb begin
        digit_off  = ascii - 8'h30;
        letter_off = ascii - 8'h41;
        is_digit   = (ascii >= 8'h30) && (ascii <= 8'h39);
        is_letter  = (ascii >= 8'h41) && (ascii <= 8'h5A);
        is_space   = (ascii == 8'h20);

        entry.cls  = CLS_SYMBOL;
        entry.code = CODE_DONE;
        if (is_space) begin
            entry.cls = CLS_WORD_GAP;
        end else if (is_digit) begin
            entry.code = digit_code(digit_off[3:0]);
        end else if (is_letter) begin
            entry.code = letter_code(letter_off[4:0]);
        end
    end
endmodule

// File: rtl/morse_unit_timer.sv
module morse_unit_timer #(
    parameter int unsigned UNIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic unit_tick
);
    localparam int unsigned CNT_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign unit_tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (unit_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (UNIT_CYCLES > 1) begin : g_spacing
            assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (rst)
                (unit_tick && !restart) |=> !unit_tick)
                else $error("unit tick repeated on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/morse_sequencer.sv
module morse_sequencer
    import morse_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  char_entry_t entry,
    input  logic        unit_tick,
    output logic        idle,
    output logic        key_q,
    output logic        lamp_q
);
    seq_state_e state_q, state_d;
    logic [7:0] code_q, code_d;
    logic [2:0] units_q, units_d;
    logic [7:0] shifted;

    assign idle    = (state_q == ST_IDLE);
    assign shifted = {code_q[6:0], 1'b0};

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        units_d = units_q;
        case (state_q)
            ST_IDLE: begin
                if (take) begin
                    code_d = entry.code;
                    if (entry.cls == CLS_WORD_GAP) begin
                        state_d = ST_TAIL;
                        units_d = UNITS_WORD;
                    end else if (entry.code == CODE_DONE) begin
                        state_d = ST_TAIL;
                        units_d = UNITS_CHAR;
                    end else begin
                        state_d = ST_MARK;
                        units_d = units_for_msb(entry.code);
                    end
                end
            end
            ST_MARK: begin
                if (unit_tick) begin
                    if (units_q == 3'd1) begin
                        state_d = ST_GAP;
                        units_d = UNITS_GAP;
                    end else begin
                        units_d = units_q - 3'd1;
                    end
                end
            end
            ST_GAP: begin
                if (unit_tick) begin
                    code_d = shifted;
                    if (shifted == CODE_DONE) begin
                        state_d = ST_TAIL;
                        units_d = UNITS_CHAR;
                    end else begin
                        state_d = ST_MARK;
                        units_d = units_for_msb(shifted);
                    end
                end
            end
            default: begin
                if (unit_tick) begin
                    if (units_q == 3'd1) begin
                        state_d = ST_IDLE;
                        units_d = '0;
                    end else begin
                        units_d = units_q - 3'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= CODE_DONE;
            units_q <= '0;
            key_q   <= 1'b0;
            lamp_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            units_q <= units_d;
            key_q   <= (state_d == ST_MARK);
            lamp_q  <= (state_d != ST_MARK);
        end
    end

    assert_take_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> !idle)
        else $error("character taken but block still idle");

    assert_mark_has_pattern_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MARK) |-> (code_q != CODE_DONE && code_q != 8'h00))
        else $error("mark sent with exhausted code byte");

    assert_tail_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |-> !key_q)
        else $error("key on during trailing silence");

    assert_lamp_opposes_key_R9: assert property (@(posedge clk) disable iff (rst)
        key_q != lamp_q)
        else $error("lamp does not mirror key");

    assert_hold_code_R10: assert property (@(posedge clk) disable iff (rst)
        (!idle && !unit_tick) |=> $stable(code_q))
        else $error("code byte changed between unit ticks");

    assert_key_ends_on_tick_R12: assert property (@(posedge clk) disable iff (rst)
        ($fell(key_q) && !$past(rst)) |-> $past(unit_tick))
        else $error("mark ended away from a unit boundary");
endmodule

// File: rtl/morse_keyer.sv
module morse_keyer
    import morse_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES = 2500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    output logic       char_ready,
    output logic       key_out,
    output logic       lamp_n,
    output logic       busy
);
    char_entry_t entry;
    logic        take;
    logic        unit_tick;
    logic        idle;

    assign char_ready = idle;
    assign busy       = !idle;
    assign take       = char_valid && idle;

    morse_codebook u_codebook (
        .ascii (char_data),
        .entry (entry)
    );

    morse_unit_timer #(
        .UNIT_CYCLES (UNIT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (take),
        .unit_tick (unit_tick)
    );

    morse_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .entry     (entry),
        .unit_tick (unit_tick),
        .idle      (idle),
        .key_q     (key_out),
        .lamp_q    (lamp_n)
    );

    assert_key_only_busy_R1: assert property (@(posedge clk) disable iff (rst)
        key_out |-> busy)
        else $error("key on while idle");
endmodule

// File: tb/morse_keyer_bench.sv
`timescale 1ns/1ps
module morse_keyer_bench;
    localparam int U = 3;
    localparam int NV = 12;
    // [31:24] char, [23:20] kind (0 symbol, 1 space), [19:16] element count,
    // [15:0] dash mask, bit i = element i (1 = dash)
    localparam logic [31:0] VEC [NV] = '{
        {8'h45, 4'd0, 4'd1, 16'h0000},  // E .
        {8'h54, 4'd0, 4'd1, 16'h0001},  // T -
        {8'h41, 4'd0, 4'd2, 16'h0002},  // A .-
        {8'h42, 4'd0, 4'd4, 16'h0001},  // B -...
        {8'h51, 4'd0, 4'd4, 16'h000B},  // Q --.-
        {8'h5A, 4'd0, 4'd4, 16'h0003},  // Z --..
        {8'h30, 4'd0, 4'd5, 16'h001F},  // 0 -----
        {8'h35, 4'd0, 4'd5, 16'h0000},  // 5 .....
        {8'h37, 4'd0, 4'd5, 16'h0003},  // 7 --...
        {8'h39, 4'd0, 4'd5, 16'h000F},  // 9 ----.
        {8'h20, 4'd1, 4'd0, 16'h0000},  // space
        {8'h23, 4'd0, 4'd0, 16'h0000}   // '#', unknown
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_ready, key_out, lamp_n, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cur_bad;
    string cur_info;

    always #2 clk = ~clk;

    morse_keyer #(.UNIT_CYCLES(U)) u_morse_keyer (
        .clk        (clk),
        .rst        (rst),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_ready (char_ready),
        .key_out    (key_out),
        .lamp_n     (lamp_n),
        .busy       (busy)
    );

    task automatic span(input bit lvl, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!cur_bad && (key_out !== lvl || lamp_n !== !lvl || busy !== 1'b1 || char_ready !== 1'b0)) begin
                cur_bad = 1'b1;
                cur_info = $sformatf("key=%b lamp_n=%b busy=%b ready=%b exp key=%b lamp_n=%b busy=1 ready=0",
                                     key_out, lamp_n, busy, char_ready, lvl, !lvl);
            end
            char_valid = 1'b0;
        end
    endtask

    task automatic play(input logic [31:0] v, input bit junk, input string tag);
        int n;
        cur_bad = 1'b0;
        cur_info = "";
        n = int'(v[19:16]);
        @(negedge clk);
        if (char_ready !== 1'b1) begin
            cur_bad = 1'b1;
            cur_info = $sformatf("ready=%b before offer exp 1", char_ready);
        end
        char_valid = 1'b1;
        char_data  = v[31:24];
        @(posedge clk);
        if (junk) begin
            // R10: keep offering another character for the whole first span
            @(negedge clk);
            char_valid = 1'b1;
            char_data  = 8'h30;
            for (int i = 1; i < U; i++) begin
                if (!cur_bad && key_out !== 1'b1) begin
                    cur_bad = 1'b1;
                    cur_info = $sformatf("key=%b exp 1", key_out);
                end
                @(negedge clk);
            end
            if (!cur_bad && key_out !== 1'b1) begin
                cur_bad = 1'b1;
                cur_info = $sformatf("key=%b exp 1", key_out);
            end
            char_valid = 1'b0;
            span(1'b1, (v[0] ? 3 : 1) * U - U);
            span(1'b0, U);
            for (int e = 1; e < n; e++) begin
                span(1'b1, (v[e] ? 3 : 1) * U);
                span(1'b0, U);
            end
            span(1'b0, 3 * U);
        end else if (v[23:20] == 4'd1) begin
            span(1'b0, 7 * U);
        end else begin
            for (int e = 0; e < n; e++) begin
                span(1'b1, (v[e] ? 3 : 1) * U);
                span(1'b0, U);
            end
            span(1'b0, 3 * U);
        end
        @(negedge clk);
        if (!cur_bad && (busy !== 1'b0 || char_ready !== 1'b1 || key_out !== 1'b0 || lamp_n !== 1'b1)) begin
            cur_bad = 1'b1;
            cur_info = $sformatf("end busy=%b ready=%b key=%b lamp_n=%b exp 0 1 0 1",
                                 busy, char_ready, key_out, lamp_n);
        end
        checks++;
        if (cur_bad) begin
            errors++;
            $display("FAIL %s char 0x%02h: %s", tag, v[31:24], cur_info);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        checks++;
        if (key_out !== 1'b0 || lamp_n !== 1'b1 || busy !== 1'b0 || char_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset: key=%b lamp_n=%b busy=%b ready=%b exp 0 1 0 1",
                     key_out, lamp_n, busy, char_ready);
        end
        rst = 1'b0;

        // table walk: R1 R2 R5 R6 R9 R12 on every vector, back to back
        for (int k = 0; k < NV; k++) begin
            string tag;
            logic [7:0] c;
            c = VEC[k][31:24];
            if (c == 8'h20) tag = "R7 space";
            else if (c >= 8'h30 && c <= 8'h39) tag = "R4 digit R2 R5 R6 R9 R12";
            else if (c >= 8'h41 && c <= 8'h5A) tag = "R3 letter R1 R2 R5 R6 R9 R12";
            else tag = "R8 unknown";
            play(VEC[k], 1'b0, tag);
        end

        // R8 lowercase is unknown
        play({8'h61, 4'd0, 4'd0, 16'h0000}, 1'b0, "R8 lowercase");

        // R10 offers while busy are ignored
        play({8'h54, 4'd0, 4'd1, 16'h0001}, 1'b1, "R10 offer while busy");
        play({8'h41, 4'd0, 4'd2, 16'h0002}, 1'b1, "R10 offer while busy");

        // R11 reset in the middle of a character
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = 8'h51;
        @(negedge clk);
        char_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (key_out !== 1'b0 || lamp_n !== 1'b1 || busy !== 1'b0 || char_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 mid-character reset: key=%b lamp_n=%b busy=%b ready=%b exp 0 1 0 1",
                     key_out, lamp_n, busy, char_ready);
        end
        rst = 1'b0;

        // R1 works again after the abandoned character
        play({8'h45, 4'd0, 4'd1, 16'h0000}, 1'b0, "R1 after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule